// File: doc/BRIEF.md
# Parallel-Priority Bus Ownership Controller

This block sits on the master side of a shared multi-master bus. It takes a request from the logic inside the master and turns it into an active-low bus request. It watches the active-low priority grant that an external parallel resolver returns. When it is granted and the shared busy line is free, it takes the bus by driving busy low and enabling its own address and command drivers.

Every ownership decision is registered on the falling edge of the bus clock. The internal request is first passed through a synchronizer clocked on that edge. A master that owns the bus keeps it across any number of transfers for as long as it stays granted and keeps requesting. It gives the bus up only when the transfer in progress has ended, on the falling edge after its grant is withdrawn or its own request goes away. A registered priority-out output lets the same block act as one link of a serial daisy chain.

Top module: `bus_owner_ctrl`

## Requirements
- R1: An active-low reset, applied asynchronously, immediately forces `breq_n`, `busy_out_n` and `prio_out_n` high and `drv_en` low. Its release takes effect only after `RST_STAGES` falling edges of `bclk`.
- R2: `breq_n` follows the inverse of `xfer_req` with a delay of exactly `SYNC_STAGES` falling edges, both when the request is raised and when it is dropped (default 2).
- R3: While the block owns the bus and `cmd_active` is high, it keeps `busy_out_n` low even if `prio_in_n` goes high.
- R4: A requesting master that does not own the bus takes it at a falling edge only if, at that edge, `prio_in_n` is low and `busy_in_n` is high. Taking the bus drives `busy_out_n` low and `drv_en` high. It does not take the bus while `busy_in_n` is low or `prio_in_n` is high.
- R5: The owner releases the bus at the first falling edge where `cmd_active` is low and either `prio_in_n` is high or the synchronized request has dropped. Release raises `busy_out_n` and lowers `drv_en` at the same edge.
- R6: While the synchronized request stays asserted and `prio_in_n` stays low, the owner holds the bus across repeated `cmd_active` pulses.
- R7: `prio_out_n` is registered on the falling edge. It is low only when, at that edge, `prio_in_n` was low and the synchronized request was not asserted; otherwise it is high.
- R8: `drv_en` is high exactly when `busy_out_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Internal transfer request, may be asynchronous to bclk |
| prio_in_n | input | 1 | Priority grant from the resolver, low = granted |
| busy_in_n | input | 1 | Sampled shared busy line, low = bus in use |
| cmd_active | input | 1 | High while this master has a command in progress |
| breq_n | output | 1 | Bus request, low = requesting |
| prio_out_n | output | 1 | Grant passed to the next lower master in a daisy chain |
| busy_out_n | output | 1 | Drive for the shared busy line, low = owning |
| drv_en | output | 1 | Enable for the address and command drivers |

## Verification
Counting falling edges from the edge that first sees a changed input: `breq_n` moves after two edges. A takeover from idle therefore shows on `busy_out_n` after three edges, because the ownership register sees the synchronized request one edge later than the request output does. A release after `cmd_active` or the grant drops is due after one edge, and `prio_out_n` reacts one edge after `prio_in_n`. The bench changes inputs only on rising edges and reads outputs 1 ns after each falling edge. Each scenario steps edge by edge, so the sample just before a due edge must show the old value and the sample just after it the new one. The reset check is taken with no clock edge in between, to show that reset acts asynchronously.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } own_state_e;

endpackage

// File: rtl/bus_own_rst_sync.sv
module bus_own_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic bclk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] rst_q;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = rst_q[STAGES-1];

endmodule

// File: rtl/bus_own_req_sync.sv
module bus_own_req_sync #(
  parameter int STAGES = 2
) (
  input  logic bclk,
  input  logic rst_sn,
  input  logic req_in,
  output logic req_s
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(negedge bclk or negedge rst_sn) begin
        if (!rst_sn) chain_q[0] <= 1'b0;
        else         chain_q[0] <= req_in;
      end
    end else begin : g_next
      always_ff @(negedge bclk or negedge rst_sn) begin
        if (!rst_sn) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign req_s = chain_q[STAGES-1];

endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic bclk,
  input  logic rst_sn,
  input  logic req_s,
  input  logic prio_in_n,
  input  logic busy_in_n,
  input  logic cmd_active,
  output logic busy_out_n,
  output logic drv_en
);

  own_state_e state_q, state_d;
  logic       grant, bus_free;
  logic       busy_q, drv_q;
  logic       own;

  assign grant    = !prio_in_n;
  assign bus_free = busy_in_n;
  assign own      = (state_q == ST_OWN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_s) state_d = (grant && bus_free) ? ST_OWN : ST_WAIT;
      end
      ST_WAIT: begin
        if (!req_s)                 state_d = ST_IDLE;
        else if (grant && bus_free) state_d = ST_OWN;
      end
      ST_OWN: begin
        if (!cmd_active && (!grant || !req_s))
          state_d = req_s ? ST_WAIT : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(negedge bclk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d == ST_OWN);
      drv_q   <= (state_d == ST_OWN);
    end
  end

  assign busy_out_n = !busy_q;
  assign drv_en     = drv_q;

  // R3: a command in progress pins ownership
  a_r3_hold_during_cmd: assert property (@(negedge bclk) disable iff (!rst_sn)
    (own && cmd_active) |=> own);

  // R4: no takeover without grant and a free bus
  a_r4_take_needs_free: assert property (@(negedge bclk) disable iff (!rst_sn)
    (!own && !(grant && bus_free)) |=> !own);

  // R5: idle command and lost grant release the bus
  a_r5_release_on_loss: assert property (@(negedge bclk) disable iff (!rst_sn)
    (own && !cmd_active && !grant) |=> !own);

  // R6: granted requester keeps the bus
  a_r6_keep_while_granted: assert property (@(negedge bclk) disable iff (!rst_sn)
    (own && req_s && grant) |=> own);

endmodule

// File: rtl/bus_own_chain.sv
module bus_own_chain (
  input  logic bclk,
  input  logic rst_sn,
  input  logic prio_in_n,
  input  logic req_s,
  output logic prio_out_n
);

  logic pout_q, pout_d;

  always_comb pout_d = prio_in_n || req_s;

  always_ff @(negedge bclk or negedge rst_sn) begin
    if (!rst_sn) pout_q <= 1'b1;
    else         pout_q <= pout_d;
  end

  assign prio_out_n = pout_q;

endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic prio_in_n,
  input  logic busy_in_n,
  input  logic cmd_active,
  output logic breq_n,
  output logic prio_out_n,
  output logic busy_out_n,
  output logic drv_en
);

  logic rst_sn;
  logic req_s;

  bus_own_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .bclk   (bclk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  bus_own_req_sync #(.STAGES(SYNC_STAGES)) u_req (
    .bclk   (bclk),
    .rst_sn (rst_sn),
    .req_in (xfer_req),
    .req_s  (req_s)
  );

  assign breq_n = !req_s;

  bus_own_fsm u_fsm (
    .bclk       (bclk),
    .rst_sn     (rst_sn),
    .req_s      (req_s),
    .prio_in_n  (prio_in_n),
    .busy_in_n  (busy_in_n),
    .cmd_active (cmd_active),
    .busy_out_n (busy_out_n),
    .drv_en     (drv_en)
  );

  bus_own_chain u_chain (
    .bclk       (bclk),
    .rst_sn     (rst_sn),
    .prio_in_n  (prio_in_n),
    .req_s      (req_s),
    .prio_out_n (prio_out_n)
  );

  // R7: a requesting master never passes the grant down
  a_r7_pout_blocked: assert property (@(negedge bclk) disable iff (!rst_sn)
    req_s |=> prio_out_n);

  // R8: driver enable and busy agree
  a_r8_drv_matches_busy: assert property (@(negedge bclk) disable iff (!rst_sn)
    drv_en == !busy_out_n);

endmodule

// File: tb/bus_owner_ctrl_test.sv
module bus_owner_ctrl_test;

  localparam int MY = 5;
  localparam int NM = 16;

  logic bclk = 1'b1;
  logic rst_n, xfer_req, cmd_active;
  logic breq_n, prio_out_n, busy_out_n, drv_en;
  logic [NM-1:0] other_breq_n;
  logic other_busy_n;
  logic chain_mode, chain_prio;
  logic [NM-1:0] breq_vec;
  logic grant_any;
  int   grant_idx;
  logic prio_in_n, busy_in_n;
  int   checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 bclk = ~bclk;

  // parallel resolver: lowest index requesting wins
  always_comb begin
    breq_vec     = other_breq_n;
    breq_vec[MY] = breq_n;
    grant_any    = 1'b0;
    grant_idx    = 0;
    for (int i = NM-1; i >= 0; i--)
      if (!breq_vec[i]) begin grant_any = 1'b1; grant_idx = i; end
  end

  assign prio_in_n = chain_mode ? chain_prio : !(grant_any && grant_idx == MY);
  assign busy_in_n = busy_out_n & other_busy_n;

  bus_owner_ctrl uut (
    .bclk(bclk), .rst_n(rst_n), .xfer_req(xfer_req), .prio_in_n(prio_in_n),
    .busy_in_n(busy_in_n), .cmd_active(cmd_active), .breq_n(breq_n),
    .prio_out_n(prio_out_n), .busy_out_n(busy_out_n), .drv_en(drv_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic fall(); @(negedge bclk); #1; endtask
  task automatic rise(); @(posedge bclk); endtask

  task automatic own_chk(input string req, input logic owning);
    chk(req, "busy_out_n", busy_out_n, !owning);
    chk("R8", "drv_en", drv_en, owning);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; xfer_req = 1'b0; cmd_active = 1'b0;
    other_breq_n = '1; other_busy_n = 1'b1; chain_mode = 1'b0; chain_prio = 1'b1;
    fall(); fall();
    chk("R1", "breq_n", breq_n, 1'b1);
    chk("R1", "prio_out_n", prio_out_n, 1'b1);
    own_chk("R1", 1'b0);
    rise(); rst_n = 1'b1;
    repeat (4) fall();
    own_chk("R1", 1'b0);
  endtask

  task automatic t_request();
    rise(); xfer_req = 1'b1;
    fall(); chk("R2", "breq_n e1", breq_n, 1'b1); own_chk("R4", 1'b0);
    fall(); chk("R2", "breq_n e2", breq_n, 1'b0); own_chk("R4", 1'b0);
    fall(); own_chk("R4", 1'b1);
  endtask

  task automatic t_multi();
    for (int k = 0; k < 4; k++) begin
      rise(); cmd_active = 1'b1;
      fall(); own_chk("R6", 1'b1);
      rise(); cmd_active = 1'b0;
      fall(); own_chk("R6", 1'b1);
    end
  endtask

  task automatic t_preempt();
    rise(); cmd_active = 1'b1; other_breq_n[2] = 1'b0;
    fall(); own_chk("R3", 1'b1);
    fall(); own_chk("R3", 1'b1);
    rise(); cmd_active = 1'b0;
    fall(); own_chk("R5", 1'b0);
    rise(); other_busy_n = 1'b0;
    fall(); chk("R2", "breq_n kept", breq_n, 1'b0); own_chk("R4", 1'b0);
  endtask

  task automatic t_wait_busy();
    rise(); other_breq_n[2] = 1'b1;
    fall(); own_chk("R4", 1'b0);
    fall(); own_chk("R4", 1'b0);
    rise(); other_busy_n = 1'b1;
    fall(); own_chk("R4", 1'b1);
  endtask

  task automatic t_withdraw();
    rise(); xfer_req = 1'b0;
    fall(); chk("R2", "breq_n d1", breq_n, 1'b0); own_chk("R5", 1'b1);
    fall(); chk("R2", "breq_n d2", breq_n, 1'b1); own_chk("R5", 1'b1);
    fall(); own_chk("R5", 1'b0);
  endtask

  task automatic t_no_grant();
    rise(); other_breq_n[1] = 1'b0; xfer_req = 1'b1;
    repeat (5) fall();
    chk("R2", "breq_n", breq_n, 1'b0);
    own_chk("R4", 1'b0);
    rise(); other_breq_n[1] = 1'b1;
    fall(); own_chk("R4", 1'b1);
    rise(); xfer_req = 1'b0;
    repeat (4) fall();
    own_chk("R5", 1'b0);
  endtask

  task automatic t_chain();
    rise(); chain_mode = 1'b1; chain_prio = 1'b0;
    fall(); chk("R7", "pass idle", prio_out_n, 1'b0);
    rise(); chain_prio = 1'b1;
    fall(); chk("R7", "no grant", prio_out_n, 1'b1);
    rise(); chain_prio = 1'b0;
    fall(); chk("R7", "regrant", prio_out_n, 1'b0);
    rise(); xfer_req = 1'b1;
    fall(); chk("R7", "req e1", prio_out_n, 1'b0);
    fall(); chk("R7", "req e2", prio_out_n, 1'b0);
    fall(); chk("R7", "req e3", prio_out_n, 1'b1); own_chk("R4", 1'b1);
  endtask

  task automatic t_async_reset();
    rise(); #1 rst_n = 1'b0; xfer_req = 1'b0;
    #0.5;
    chk("R1", "async breq_n", breq_n, 1'b1);
    chk("R1", "async prio_out_n", prio_out_n, 1'b1);
    own_chk("R1", 1'b0);
    rise(); rst_n = 1'b1;
    fall(); own_chk("R1", 1'b0);
  endtask

  initial begin
    t_reset();
    t_request();
    t_multi();
    t_preempt();
    t_wait_busy();
    t_withdraw();
    t_no_grant();
    t_chain();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule